// File: doc/BRIEF.md
# Keyed Watchdog Timer with Power-of-Two Prescale

This block is a watchdog that advances a free-running count on pulses from a slow always-on timebase. The timebase nominally runs at 31250 Hz and arrives as a one-cycle enable on `tick`. The count is shifted right by a 4-bit scale and the low 16 bits of the result are compared with a programmable compare word. A hit latches an interrupt-pending flag. If the reset enable is set, the hit also produces a single-cycle reset request.

Software reaches the block over a plain 32-bit write strobe and a combinational read port. Every register that changes timer behaviour is guarded. A write to it takes effect only if the write just before it on a guarded register was an unlock word written to the key register, and each guarded write uses up the unlock. A magic word written to the feed register restarts the count. Counting can be enabled permanently, or only while the `core_awake` input is high. Optionally the count returns to zero on a hit, which gives a periodic timeout.

Top module: `wdk_top`

## Requirements
- R1: After reset the control word (offset 0x00) and the count (0x08) read 0, the compare register (0x20) reads 0x0000FFFF, and `irq` and `rst_req` are low.
- R2: A write to a guarded register (control 0x00, count 0x08, feed 0x18, compare 0x20) is ignored unless the key register (0x1C) last received 0x0051F15E.
- R3: The unlock is used up by the first guarded write after it, whether or not that write changes anything. A key write of any other value cancels a pending unlock.
- R4: An unlocked write of 0x0D09F00D to the feed register clears the count. An unlocked feed write of any other value leaves the count unchanged.
- R5: On each `tick` the count increments if control bit 12 is set, or if control bit 13 is set and `core_awake` is high. Otherwise the count holds.
- R6: Offset 0x10 reads the count shifted right by the scale held in control bits [3:0].
- R7: When the low 16 bits of the scaled count equal the compare value, control bit 28 (pending) is set and `irq` goes high. Both stay set until an unlocked control write with bit 28 clear, while no match is present.
- R8: With control bit 9 set, a match clears the count on the next clock.
- R9: With control bit 8 set, `rst_req` is high for exactly one cycle when pending becomes set. With bit 8 clear it stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-cycle timebase pulse |
| core_awake | input | 1 | High while the core is running |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 6 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` (combinational) |
| irq | output | 1 | Interrupt pending |
| rst_req | output | 1 | One-cycle reset request |

## Verification
The assertions assume that a write is a single-cycle strobe with address and data valid in the same cycle. They also assume that the count never wraps within a run, and that the key and a guarded register are never written in the same cycle, which one write port rules out anyway. The stimulus issues each write as one isolated strobe and keeps the count far below its top value. It places compare values so that a match occurs only after the tick the test intends.

// File: rtl/wdk_pkg.sv
`timescale 1ns/1ps
package wdk_pkg;
  localparam int ADDR_W = 6;
  localparam int DATA_W = 32;

  localparam logic [DATA_W-1:0] UNLOCK_WORD = 32'h0051_F15E;
  localparam logic [DATA_W-1:0] FEED_WORD   = 32'h0D09_F00D;

  localparam logic [ADDR_W-1:0] OFS_CTRL = 6'h00;
  localparam logic [ADDR_W-1:0] OFS_CNT  = 6'h08;
  localparam logic [ADDR_W-1:0] OFS_SCNT = 6'h10;
  localparam logic [ADDR_W-1:0] OFS_FEED = 6'h18;
  localparam logic [ADDR_W-1:0] OFS_KEY  = 6'h1C;
  localparam logic [ADDR_W-1:0] OFS_CMP  = 6'h20;

  localparam int B_RSTEN  = 8;
  localparam int B_ZERO   = 9;
  localparam int B_ALWAYS = 12;
  localparam int B_AWAKE  = 13;
  localparam int B_PEND   = 28;

  typedef struct packed {
    logic [3:0] scale;
    logic       rst_en;
    logic       zero_en;
    logic       run_always;
    logic       run_awake;
  } ctl_t;

  function automatic ctl_t ctl_from_word(input logic [DATA_W-1:0] w);
    ctl_t c;
    c.scale      = w[3:0];
    c.rst_en     = w[B_RSTEN];
    c.zero_en    = w[B_ZERO];
    c.run_always = w[B_ALWAYS];
    c.run_awake  = w[B_AWAKE];
    return c;
  endfunction

  function automatic logic [DATA_W-1:0] ctl_to_word(input ctl_t c, input logic pend);
    logic [DATA_W-1:0] w;
    w           = '0;
    w[3:0]      = c.scale;
    w[B_RSTEN]  = c.rst_en;
    w[B_ZERO]   = c.zero_en;
    w[B_ALWAYS] = c.run_always;
    w[B_AWAKE]  = c.run_awake;
    w[B_PEND]   = pend;
    return w;
  endfunction

  function automatic logic [DATA_W-1:0] scale_down(input logic [DATA_W-1:0] cnt,
                                                   input logic [3:0] sc);
    return cnt >> sc;
  endfunction

  function automatic logic is_guarded(input logic [ADDR_W-1:0] a);
    return (a == OFS_CTRL) || (a == OFS_CNT) || (a == OFS_FEED) || (a == OFS_CMP);
  endfunction
endpackage

// File: rtl/wdk_regs.sv
`timescale 1ns/1ps
module wdk_regs
  import wdk_pkg::*;
#(
  parameter int CMP_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_wr,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DATA_W-1:0]   bus_wdata,
  output ctl_t                ctl_q,
  output logic [CMP_W-1:0]    cmp_q,
  output logic                ctrl_wr,
  output logic                cnt_wr,
  output logic                feed_clr
);
  logic unlock_q;
  logic guarded_wr;
  logic accept;
  logic key_wr;

  assign key_wr     = bus_wr && (bus_addr == OFS_KEY);
  assign guarded_wr = bus_wr && is_guarded(bus_addr);
  assign accept     = guarded_wr && unlock_q;
  assign ctrl_wr    = accept && (bus_addr == OFS_CTRL);
  assign cnt_wr     = accept && (bus_addr == OFS_CNT);
  assign feed_clr   = accept && (bus_addr == OFS_FEED) && (bus_wdata == FEED_WORD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          unlock_q <= 1'b0;
    else if (key_wr)     unlock_q <= (bus_wdata == UNLOCK_WORD);
    else if (guarded_wr) unlock_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
      cmp_q <= '1;
    end else begin
      if (ctrl_wr) ctl_q <= ctl_from_word(bus_wdata);
      if (accept && (bus_addr == OFS_CMP)) cmp_q <= bus_wdata[CMP_W-1:0];
    end
  end

  // R2
  locked_write_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (guarded_wr && !unlock_q) |=> ($stable(ctl_q) && $stable(cmp_q)));

  // R3
  unlock_consumed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    guarded_wr |=> !unlock_q);
endmodule

// File: rtl/wdk_counter.sv
`timescale 1ns/1ps
module wdk_counter
  import wdk_pkg::*;
#(
  parameter int CNT_W = 31,
  parameter int CMP_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic               core_awake,
  input  ctl_t               ctl,
  input  logic [CMP_W-1:0]   cmp,
  input  logic               cnt_wr,
  input  logic [CNT_W-1:0]   cnt_wdata,
  input  logic               feed_clr,
  input  logic               pend_wr,
  input  logic               pend_wdata,
  output logic [DATA_W-1:0]  cnt_word,
  output logic [DATA_W-1:0]  scaled,
  output logic               pend_q
);
  localparam int PAD = DATA_W - CNT_W;

  logic [CNT_W-1:0] cnt_q;
  logic             advance;
  logic             hit;

  assign cnt_word = {{PAD{1'b0}}, cnt_q};
  assign scaled   = scale_down(cnt_word, ctl.scale);
  assign hit      = (scaled[CMP_W-1:0] == cmp);
  assign advance  = tick && (ctl.run_always || (ctl.run_awake && core_awake));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    cnt_q <= '0;
    else if (cnt_wr)               cnt_q <= cnt_wdata;
    else if (feed_clr)             cnt_q <= '0;
    else if (hit && ctl.zero_en)   cnt_q <= '0;
    else if (advance)              cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pend_q <= 1'b0;
    else if (hit)     pend_q <= 1'b1;
    else if (pend_wr) pend_q <= pend_wdata;
  end

  // R4
  feed_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    feed_clr |=> (cnt_q == '0));

  // R5
  idle_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !cnt_wr && !feed_clr && !(hit && ctl.zero_en)) |=> $stable(cnt_q));

  // R7
  match_sets_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit |=> pend_q);
endmodule

// File: rtl/wdk_rstgen.sv
`timescale 1ns/1ps
module wdk_rstgen (
  input  logic clk,
  input  logic rst_n,
  input  logic pend,
  input  logic rst_en,
  output logic rst_req
);
  logic armed;
  logic armed_q;

  assign armed   = pend && rst_en;
  assign rst_req = armed && !armed_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= armed;
  end

  // R9
  rst_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);
endmodule

// File: rtl/wdk_top.sv
`timescale 1ns/1ps
module wdk_top
  import wdk_pkg::*;
#(
  parameter int CNT_W = 31,
  parameter int CMP_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              core_awake,
  input  logic              bus_wr,
  input  logic [5:0]        bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              irq,
  output logic              rst_req
);
  ctl_t              ctl;
  logic [CMP_W-1:0]  cmp;
  logic              ctrl_wr;
  logic              cnt_wr;
  logic              feed_clr;
  logic [DATA_W-1:0] cnt_word;
  logic [DATA_W-1:0] scaled;
  logic              pend;

  wdk_regs #(.CMP_W(CMP_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .ctl_q(ctl), .cmp_q(cmp), .ctrl_wr(ctrl_wr),
    .cnt_wr(cnt_wr), .feed_clr(feed_clr)
  );

  wdk_counter #(.CNT_W(CNT_W), .CMP_W(CMP_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick), .core_awake(core_awake),
    .ctl(ctl), .cmp(cmp), .cnt_wr(cnt_wr), .cnt_wdata(bus_wdata[CNT_W-1:0]),
    .feed_clr(feed_clr), .pend_wr(ctrl_wr), .pend_wdata(bus_wdata[B_PEND]),
    .cnt_word(cnt_word), .scaled(scaled), .pend_q(pend)
  );

  wdk_rstgen u_rst (
    .clk(clk), .rst_n(rst_n), .pend(pend), .rst_en(ctl.rst_en), .rst_req(rst_req)
  );

  assign irq = pend;

  always_comb begin
    unique case (bus_addr)
      OFS_CTRL: bus_rdata = ctl_to_word(ctl, pend);
      OFS_CNT:  bus_rdata = cnt_word;
      OFS_SCNT: bus_rdata = scaled;
      OFS_CMP:  bus_rdata = {{(DATA_W-CMP_W){1'b0}}, cmp};
      default:  bus_rdata = '0;
    endcase
  end

  // R7
  irq_follows_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> (bus_rdata[B_PEND] || bus_addr != OFS_CTRL));
endmodule

// File: tb/sim_wdk_top.sv
`timescale 1ns/1ps
module sim_wdk_top;
  localparam logic [5:0] A_CTRL = 6'h00, A_CNT = 6'h08, A_SCNT = 6'h10,
                         A_FEED = 6'h18, A_KEY = 6'h1C, A_CMP = 6'h20;
  localparam logic [31:0] KEY_OK = 32'h0051_F15E, FEED_OK = 32'h0D09_F00D;
  localparam logic [31:0] F_ALWAYS = 32'h1000, F_AWAKE = 32'h2000,
                          F_RSTEN = 32'h100, F_ZERO = 32'h200, F_PEND = 32'h1000_0000;

  typedef struct {
    int          kind;   // 0 read data, 1 irq, 2 rst_req
    logic [31:0] exp;
    string       tag;
  } item_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic core_awake = 1'b0;
  logic bus_wr = 1'b0;
  logic [5:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic irq, rst_req;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  item_t sb[$];

  always #2.5 clk = ~clk;

  wdk_top u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .core_awake(core_awake),
    .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq), .rst_req(rst_req)
  );

  // monitor: pops every expected item queued at this negedge
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (sb.size() > 0) begin
        item_t it;
        logic [31:0] act;
        it = sb.pop_front();
        act = (it.kind == 0) ? bus_rdata : (it.kind == 1) ? {31'b0, irq} : {31'b0, rst_req};
        checks++;
        if (act !== it.exp) begin
          errors++;
          $display("FAIL %s: actual=%h expected=%h", it.tag, act, it.exp);
        end
      end
    end
  end

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic kwr(input logic [5:0] a, input logic [31:0] d);
    wr(A_KEY, KEY_OK);
    wr(a, d);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic chk_reg(input logic [5:0] a, input logic [31:0] e, input string tag);
    item_t it;
    @(negedge clk);
    bus_addr = a;
    it.kind = 0; it.exp = e; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic chk_pin(input int k, input logic e, input string tag);
    item_t it;
    it.kind = k; it.exp = {31'b0, e}; it.tag = tag;
    sb.push_back(it);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk_reg(A_CTRL, 32'h0, "R1 ctrl");
    chk_pin(1, 1'b0, "R1 irq");
    chk_pin(2, 1'b0, "R1 rst_req");
    chk_reg(A_CNT, 32'h0, "R1 count");
    chk_reg(A_CMP, 32'h0000_FFFF, "R1 compare");

    // R2 locked write ignored
    wr(A_CMP, 32'd100);
    chk_reg(A_CMP, 32'h0000_FFFF, "R2 locked compare write");
    kwr(A_CMP, 32'd100);
    chk_reg(A_CMP, 32'd100, "R2 unlocked compare write");

    // R3 unlock consumed, wrong key cancels
    wr(A_CMP, 32'd7);
    chk_reg(A_CMP, 32'd100, "R3 second write without key");
    wr(A_KEY, KEY_OK);
    wr(A_KEY, 32'h1234);
    wr(A_CMP, 32'd7);
    chk_reg(A_CMP, 32'd100, "R3 wrong key cancels");

    // R5 counting modes
    kwr(A_CTRL, F_ALWAYS);
    ticks(3);
    chk_reg(A_CNT, 32'd3, "R5 always mode");
    kwr(A_CTRL, F_AWAKE);
    core_awake = 1'b0;
    ticks(2);
    chk_reg(A_CNT, 32'd3, "R5 awake mode asleep");
    core_awake = 1'b1;
    ticks(2);
    chk_reg(A_CNT, 32'd5, "R5 awake mode awake");
    kwr(A_CTRL, 32'h0);
    ticks(2);
    chk_reg(A_CNT, 32'd5, "R5 disabled holds");

    // R6 scaled view
    kwr(A_CTRL, F_ALWAYS | 32'd2);
    chk_reg(A_SCNT, 32'd1, "R6 scale 2 of 5");

    // R4 feed
    kwr(A_FEED, 32'h1234);
    chk_reg(A_CNT, 32'd5, "R4 wrong feed word");
    kwr(A_FEED, FEED_OK);
    chk_reg(A_CNT, 32'd0, "R4 feed clears");

    // R7 match sets pending, rst_en off
    kwr(A_CMP, 32'd3);
    kwr(A_CTRL, F_ALWAYS);
    ticks(2);
    chk_pin(1, 1'b0, "R7 no match yet");
    ticks(1);
    step();
    chk_pin(1, 1'b1, "R7 irq on match");
    chk_pin(2, 1'b0, "R9 no reset when disabled");
    ticks(1);
    chk_reg(A_CTRL, F_ALWAYS | F_PEND, "R7 pending sticky");
    kwr(A_CTRL, F_ALWAYS);
    chk_reg(A_CTRL, F_ALWAYS, "R7 pending cleared");
    chk_pin(1, 1'b0, "R7 irq cleared");

    // R9 and R8: reset pulse and zero-on-match
    kwr(A_FEED, FEED_OK);
    kwr(A_CTRL, F_ALWAYS | F_RSTEN | F_ZERO);
    ticks(3);
    step();
    chk_pin(2, 1'b1, "R9 reset pulse");
    chk_pin(1, 1'b1, "R9 irq with pulse");
    chk_reg(A_CNT, 32'd0, "R8 zero on match");
    chk_pin(2, 1'b0, "R9 pulse one cycle");

    // R6/R7 scaled compare
    kwr(A_FEED, FEED_OK);
    kwr(A_CMP, 32'd2);
    kwr(A_CTRL, F_ALWAYS | 32'd1);
    ticks(3);
    step();
    chk_pin(1, 1'b0, "R7 scaled 1 no match");
    ticks(1);
    step();
    chk_pin(1, 1'b1, "R7 scaled 2 matches");
    chk_reg(A_SCNT, 32'd2, "R6 scale 1 of 4");

    repeat (3) step();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule